// File: doc/BRIEF.md
# Reconfigurable lock-step bus checker

This block stands between four processor cores and one shared bus. Each cycle it looks at the bus request of every core (valid, write enable, address, write data). It then decides, according to the operating mode, which request may reach the bus. The mode can be changed while the system runs. In vote mode the four cores run the same code as one channel, and a request goes out when at least three of them agree, which hides a single faulty core. In pair mode cores 0/1 and cores 2/3 form two separate channels, and a channel whose two cores disagree is silenced. In free mode every core is its own channel and nothing is compared.

The checker compares only what the cores put on the bus. A round-robin arbiter picks one request per cycle among the channels that are allowed to go out. The cores of the winning channel get a combinational grant, and the chosen transaction appears on the bus one cycle later from a register. A read blocks further grants until its data returns. The returned data is then handed to every core of the channel that issued the read. Fault flags stay set until software pulses the clear input.

Top module: `lockstep_gate`

## Requirements
- R1: In vote mode (mode code 0), when all four cores present the same request, all four `core_gnt` bits are raised together and that request is forwarded on bus channel 0.
- R2: In vote mode, when exactly three cores agree, their request is forwarded. The `masked_core` bit of the dissenting core (bit i for core i) is set, and `vote_fatal` stays clear.
- R3: In vote mode, when no three cores agree (for example a 2-2 split), no grant is given, nothing reaches the bus, and `vote_fatal` is set.
- R4: In pair mode (mode code 1), pair 0 is cores 0 and 1 and pair 1 is cores 2 and 3. An agreeing pair gets `core_gnt` 4'b0011 or 4'b1100, and its request is forwarded with `bus_chan` equal to the pair number.
- R5: In pair mode, a pair whose cores disagree gets no grant and sets its `pair_err` bit (bit p for pair p). The other pair keeps being served.
- R6: In free mode (mode code 2), each core is channel i with `core_gnt` bit i. One grant is given per cycle, in round-robin order starting from the channel after the last one granted (channel 0 is first after reset).
- R7: Two requests agree when their valid bits match and, if valid, their address and write enable match. Write data is compared only for writes, so reads that differ only in write data agree.
- R8: A request granted in cycle N appears on the bus outputs in cycle N+1, for exactly one cycle, with its own address, write enable, write data (for writes) and channel number.
- R9: After a read is issued, no grant is given until `bus_rvalid`. In the `bus_rvalid` cycle, `core_rvalid` is raised for every core of the issuing channel and `core_rdata` carries `bus_rdata`.
- R10: `mode_cur` takes the value of `mode_req` only at an edge where no read is outstanding and the bus output is idle. Mode code 3 is ignored.
- R11: `masked_core`, `vote_fatal` and `pair_err` stay set until `err_clr` is pulsed, which clears them.
- R12: After reset the bus output and grants are idle, all fault flags are clear, and `mode_cur` is vote mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Requested operating mode (0 vote, 1 pair, 2 free, 3 ignored) |
| err_clr | input | 1 | Clears all fault flags |
| core_vld | input | 4 | Request valid, one bit per core |
| core_we | input | 4 | Write enable, one bit per core |
| core_addr | input | 4*AW | Address, core i at bits [i*AW +: AW] |
| core_wdata | input | 4*DW | Write data, core i at bits [i*DW +: DW] |
| core_gnt | output | 4 | Grant to the cores of the winning channel |
| core_rvalid | output | 4 | Read data valid to the cores of the reading channel |
| core_rdata | output | DW | Read data broadcast |
| bus_vld | output | 1 | Bus transaction valid |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_chan | output | 2 | Channel that issued the transaction |
| bus_rvalid | input | 1 | Read data returned by the bus |
| bus_rdata | input | DW | Read data from the bus |
| mode_cur | output | 2 | Mode in force |
| masked_core | output | 4 | Sticky: core outvoted in vote mode |
| vote_fatal | output | 1 | Sticky: no majority in vote mode |
| pair_err | output | 2 | Sticky: pair mismatch in pair mode |

## Verification
Some rules are checked by the assertions on every cycle:
- grants stay one channel at a time and only go to requesting channels;
- a split vote or a mismatched pair never leads to a grant or a bus transaction;
- at most one core is outvoted;
- no grant is given while a read is outstanding;
- the mode does not move while a read is outstanding or the bus output is busy;
- fault flags hold until cleared.

Other behaviour can only be shown by the bench scenarios: which transaction is forwarded and in which cycle, that reads with different write data agree, the round-robin order across channels, that the read data reaches the right cores, and that mode code 3 is ignored.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  localparam int NCORE = 4;
  localparam int NPAIR = NCORE / 2;

  typedef enum logic [1:0] {
    MODE_VOTE = 2'd0,
    MODE_PAIR = 2'd1,
    MODE_FREE = 2'd2
  } mode_e;
endpackage

// File: rtl/lsg_txeq.sv
module lsg_txeq #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          a_vld,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          b_vld,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          eq
);
  // Two bus requests are the same when their valid bits match; for valid
  // requests address and direction must match, and data only for writes.
  function automatic logic same_req(
    input logic va, input logic wa, input logic [AW-1:0] aa, input logic [DW-1:0] da,
    input logic vb, input logic wb, input logic [AW-1:0] ab, input logic [DW-1:0] db);
    logic r;
    r = (va == vb);
    if (va && vb) begin
      r = (aa == ab) && (wa == wb) && (!wa || (da == db));
    end
    return r;
  endfunction

  always_comb eq = same_req(a_vld, a_we, a_addr, a_wdata, b_vld, b_we, b_addr, b_wdata);
endmodule

// File: rtl/lsg_vote.sv
module lsg_vote import lsg_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int CW = $clog2(NCORE),
  localparam int QUORUM = NCORE - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    vld,
  input  logic [NCORE-1:0]    we,
  input  logic [NCORE*AW-1:0] addr,
  input  logic [NCORE*DW-1:0] wdata,
  output logic                maj_req,
  output logic [CW-1:0]       maj_idx,
  output logic [NCORE-1:0]    dissent,
  output logic                split
);
  logic [NCORE*NCORE-1:0] agree;
  logic                   maj_ok;

  for (genvar i = 0; i < NCORE; i++) begin : g_row
    for (genvar j = 0; j < NCORE; j++) begin : g_col
      if (i == j) begin : g_self
        assign agree[i*NCORE+j] = 1'b1;
      end else if (i < j) begin : g_cmp
        lsg_txeq #(.AW(AW), .DW(DW)) u_eq (
          .a_vld(vld[i]), .a_we(we[i]), .a_addr(addr[i*AW +: AW]), .a_wdata(wdata[i*DW +: DW]),
          .b_vld(vld[j]), .b_we(we[j]), .b_addr(addr[j*AW +: AW]), .b_wdata(wdata[j*DW +: DW]),
          .eq(agree[i*NCORE+j])
        );
      end else begin : g_mirror
        assign agree[i*NCORE+j] = agree[j*NCORE+i];
      end
    end
  end

  // number of cores (including itself) holding the same request as core i
  function automatic int backers(input logic [NCORE*NCORE-1:0] m, input int i);
    return $countones(m[i*NCORE +: NCORE]);
  endfunction

  always_comb begin
    maj_ok  = 1'b0;
    maj_idx = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (backers(agree, i) >= QUORUM) begin
        maj_ok  = 1'b1;
        maj_idx = CW'(i);
      end
    end
    for (int i = 0; i < NCORE; i++) begin
      dissent[i] = maj_ok && !agree[int'(maj_idx)*NCORE + i];
    end
    split   = !maj_ok;
    maj_req = maj_ok && vld[maj_idx];
  end

  // R2: a quorum leaves at most one core outvoted
  assert_single_dissent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !split |-> $countones(dissent) <= 1);
  // R3: without a quorum nobody is singled out
  assert_split_no_blame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    split |-> (dissent == '0) && !maj_req);
endmodule

// File: rtl/lsg_pair.sv
module lsg_pair #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic [1:0]      vld,
  input  logic [1:0]      we,
  input  logic [2*AW-1:0] addr,
  input  logic [2*DW-1:0] wdata,
  output logic            req,
  output logic            miss
);
  logic eq;

  lsg_txeq #(.AW(AW), .DW(DW)) u_eq (
    .a_vld(vld[0]), .a_we(we[0]), .a_addr(addr[0 +: AW]), .a_wdata(wdata[0 +: DW]),
    .b_vld(vld[1]), .b_we(we[1]), .b_addr(addr[AW +: AW]), .b_wdata(wdata[DW +: DW]),
    .eq(eq)
  );

  assign req  = eq && vld[0];
  assign miss = !eq;
endmodule

// File: rtl/lsg_rr_arb.sv
module lsg_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] last_q;

  always_comb begin
    int idx;
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (en && !any && req[idx]) begin
        any     = 1'b1;
        gnt_idx = IW'(idx);
      end
    end
    gnt = any ? (N'(1) << gnt_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (any) begin
      last_q <= gnt_idx;
    end
  end

  // R6: one channel at a time, and only a requesting one
  assert_gnt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/lockstep_gate.sv
module lockstep_gate import lsg_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_req,
  input  logic                err_clr,
  input  logic [NCORE-1:0]    core_vld,
  input  logic [NCORE-1:0]    core_we,
  input  logic [NCORE*AW-1:0] core_addr,
  input  logic [NCORE*DW-1:0] core_wdata,
  output logic [NCORE-1:0]    core_gnt,
  output logic [NCORE-1:0]    core_rvalid,
  output logic [DW-1:0]       core_rdata,
  output logic                bus_vld,
  output logic                bus_we,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  output logic [1:0]          bus_chan,
  input  logic                bus_rvalid,
  input  logic [DW-1:0]       bus_rdata,
  output logic [1:0]          mode_cur,
  output logic [NCORE-1:0]    masked_core,
  output logic                vote_fatal,
  output logic [NPAIR-1:0]    pair_err
);
  localparam int CW = $clog2(NCORE);

  mode_e            mode_q;
  logic             rd_pend;
  logic [NCORE-1:0] rd_mask;
  logic             maj_req;
  logic [CW-1:0]    maj_idx;
  logic [NCORE-1:0] dissent;
  logic             vote_split;
  logic [NPAIR-1:0] pair_req;
  logic [NPAIR-1:0] pair_miss;
  logic [NCORE-1:0] ch_req;
  logic [NCORE-1:0] ch_gnt;
  logic [CW-1:0]    win;
  logic             win_any;
  logic [CW-1:0]    src;
  logic             bus_idle;

  // ---------------- comparator fabric ----------------
  lsg_vote #(.AW(AW), .DW(DW)) u_vote (
    .clk(clk), .rst_n(rst_n),
    .vld(core_vld), .we(core_we), .addr(core_addr), .wdata(core_wdata),
    .maj_req(maj_req), .maj_idx(maj_idx), .dissent(dissent), .split(vote_split)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    lsg_pair #(.AW(AW), .DW(DW)) u_pair (
      .vld(core_vld[2*p +: 2]), .we(core_we[2*p +: 2]),
      .addr(core_addr[2*p*AW +: 2*AW]), .wdata(core_wdata[2*p*DW +: 2*DW]),
      .req(pair_req[p]), .miss(pair_miss[p])
    );
  end

  // ---------------- channel mapping ----------------
  function automatic logic [NCORE-1:0] chan_mask(input mode_e m, input logic [CW-1:0] ch);
    case (m)
      MODE_VOTE: return '1;
      MODE_PAIR: return NCORE'(2'b11) << (2 * int'(ch));
      default:   return NCORE'(1) << ch;
    endcase
  endfunction

  function automatic logic [CW-1:0] src_core(input mode_e m, input logic [CW-1:0] ch,
                                             input logic [CW-1:0] maj);
    case (m)
      MODE_VOTE: return maj;
      MODE_PAIR: return CW'(2 * int'(ch));
      default:   return ch;
    endcase
  endfunction

  always_comb begin
    case (mode_q)
      MODE_VOTE: ch_req = {{(NCORE-1){1'b0}}, maj_req};
      MODE_PAIR: ch_req = {{(NCORE-NPAIR){1'b0}}, pair_req};
      default:   ch_req = core_vld;
    endcase
  end

  lsg_rr_arb #(.N(NCORE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ch_req), .en(!rd_pend),
    .gnt(ch_gnt), .gnt_idx(win), .any(win_any)
  );

  assign src      = src_core(mode_q, win, maj_idx);
  assign core_gnt = win_any ? chan_mask(mode_q, win) : '0;
  assign bus_idle = !rd_pend && !bus_vld;

  // ---------------- bus side ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_vld   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_chan  <= '0;
      rd_pend   <= 1'b0;
      rd_mask   <= '0;
    end else begin
      bus_vld <= win_any;
      if (win_any) begin
        bus_we    <= core_we[src];
        bus_addr  <= core_addr[int'(src)*AW +: AW];
        bus_wdata <= core_wdata[int'(src)*DW +: DW];
        bus_chan  <= 2'(win);
      end
      if (win_any && !core_we[src]) begin
        rd_pend <= 1'b1;
        rd_mask <= chan_mask(mode_q, win);
      end else if (rd_pend && bus_rvalid) begin
        rd_pend <= 1'b0;
      end
    end
  end

  assign core_rvalid = (rd_pend && bus_rvalid) ? rd_mask : '0;
  assign core_rdata  = bus_rdata;

  // ---------------- mode and fault flags ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_VOTE;
    end else if (bus_idle && mode_req != 2'd3) begin
      mode_q <= mode_e'(mode_req);
    end
  end
  assign mode_cur = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n || err_clr) begin
      masked_core <= '0;
      vote_fatal  <= 1'b0;
      pair_err    <= '0;
    end else begin
      if (mode_q == MODE_VOTE) begin
        masked_core <= masked_core | dissent;
        vote_fatal  <= vote_fatal | vote_split;
      end
      if (mode_q == MODE_PAIR) begin
        pair_err <= pair_err | pair_miss;
      end
    end
  end

  // ---------------- assertions ----------------
  // R3: a split vote never produces a bus transaction
  assert_split_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_VOTE && vote_split) |=> !bus_vld);
  // R5: a mismatched pair gets no grant
  assert_pair0_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAIR && pair_miss[0]) |-> !core_gnt[0] && !core_gnt[1]);
  assert_pair1_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PAIR && pair_miss[1]) |-> !core_gnt[2] && !core_gnt[3]);
  // R9: no grant while a read is outstanding
  assert_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> core_gnt == '0);
  // R10: mode frozen while traffic is in flight
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend || bus_vld) |=> $stable(mode_q));
  // R11: flags hold until cleared
  assert_fatal_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_fatal && !err_clr) |=> vote_fatal);
  assert_pair_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_err != '0 && !err_clr) |=> (pair_err & $past(pair_err)) == $past(pair_err));
endmodule

// File: tb/sim_lockstep_gate.sv
module sim_lockstep_gate;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_req;
  logic err_clr;
  logic [NC-1:0] core_vld, core_we;
  logic [NC*AW-1:0] core_addr;
  logic [NC*DW-1:0] core_wdata;
  logic [NC-1:0] core_gnt, core_rvalid;
  logic [DW-1:0] core_rdata;
  logic bus_vld, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [1:0] bus_chan;
  logic bus_rvalid;
  logic [DW-1:0] bus_rdata;
  logic [1:0] mode_cur;
  logic [NC-1:0] masked_core;
  logic vote_fatal;
  logic [1:0] pair_err;

  typedef struct {
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;
    logic [1:0]    ch;
    int            cyc;
  } item_t;

  item_t q[$];
  item_t mon_e;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lockstep_gate #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .err_clr(err_clr),
    .core_vld(core_vld), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_gnt(core_gnt), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
    .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_chan(bus_chan), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .mode_cur(mode_cur), .masked_core(masked_core), .vote_fatal(vote_fatal), .pair_err(pair_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_core(input int i, input logic v, input logic w,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    core_vld[i] = v;
    core_we[i]  = w;
    core_addr[i*AW +: AW]  = a;
    core_wdata[i*DW +: DW] = d;
  endtask

  task automatic put_all(input logic v, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int i = 0; i < NC; i++) set_core(i, v, w, a, d);
  endtask

  task automatic push(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input logic [1:0] ch);
    item_t e;
    e.a = a; e.w = w; e.d = d; e.ch = ch; e.cyc = cyc + 1;  // R8: one cycle later
    q.push_back(e);
  endtask

  task automatic pulse_clear();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // monitor: every bus transaction must match the next expected item (R8)
  always @(negedge clk) begin
    if (rst_n && bus_vld) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected bus transaction actual=%0h expected=none", bus_addr);
      end else begin
        mon_e = q.pop_front();
        chk("R8 bus_addr", 64'(bus_addr), 64'(mon_e.a));
        chk("R8 bus_we", 64'(bus_we), 64'(mon_e.w));
        chk("R8 bus_chan", 64'(bus_chan), 64'(mon_e.ch));
        chk("R8 issue cycle", 64'(cyc), 64'(mon_e.cyc));
        if (mon_e.w) chk("R8 bus_wdata", 64'(bus_wdata), 64'(mon_e.d));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_req = 2'd0; err_clr = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
    core_vld = '0; core_we = '0; core_addr = '0; core_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12 bus_vld", 64'(bus_vld), 0);
    chk("R12 core_gnt", 64'(core_gnt), 0);
    chk("R12 mode_cur", 64'(mode_cur), 0);
    chk("R12 flags", 64'({masked_core, vote_fatal, pair_err}), 0);

    // R1: unanimous write in vote mode
    @(negedge clk); put_all(1, 1, 16'h1000, 32'hA5A5_0001); #1;
    chk("R1 core_gnt", 64'(core_gnt), 64'hF);
    push(16'h1000, 1, 32'hA5A5_0001, 0);
    @(negedge clk); put_all(0, 0, 0, 0);
    repeat (2) @(negedge clk);

    // R2: core 2 disagrees, majority forwarded
    put_all(1, 1, 16'h2000, 32'h11); set_core(2, 1, 1, 16'h2004, 32'h11); #1;
    chk("R2 core_gnt", 64'(core_gnt), 64'hF);
    push(16'h2000, 1, 32'h11, 0);
    @(negedge clk); put_all(0, 0, 0, 0); #1;
    chk("R2 masked_core", 64'(masked_core), 64'b0100);
    chk("R2 vote_fatal", 64'(vote_fatal), 0);
    @(negedge clk); #1;
    chk("R11 masked sticky", 64'(masked_core), 64'b0100);
    pulse_clear(); #1;
    chk("R11 masked cleared", 64'(masked_core), 0);

    // R3: 2-2 split
    @(negedge clk);
    put_all(1, 1, 16'h3000, 32'h22); set_core(2, 1, 1, 16'h3004, 32'h22); set_core(3, 1, 1, 16'h3004, 32'h22); #1;
    chk("R3 core_gnt", 64'(core_gnt), 0);
    @(negedge clk); #1;
    chk("R3 vote_fatal", 64'(vote_fatal), 1);
    chk("R3 masked_core", 64'(masked_core), 0);
    put_all(0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R11 fatal sticky", 64'(vote_fatal), 1);
    pulse_clear(); #1;
    chk("R11 fatal cleared", 64'(vote_fatal), 0);

    // R7: reads differing only in write data agree; R9 stall and return
    @(negedge clk);
    for (int i = 0; i < NC; i++) set_core(i, 1, 0, 16'h4000, 32'h100 + i);
    #1;
    chk("R7 core_gnt", 64'(core_gnt), 64'hF);
    push(16'h4000, 0, 0, 0);
    @(negedge clk); put_all(1, 1, 16'h4100, 32'h77); #1;
    chk("R9 stalled", 64'(core_gnt), 0);
    chk("R7 no masked", 64'({masked_core, vote_fatal}), 0);
    @(negedge clk); #1;
    chk("R9 still stalled", 64'(core_gnt), 0);
    @(negedge clk); bus_rvalid = 1'b1; bus_rdata = 32'hCAFE_0123; #1;
    chk("R9 core_rvalid", 64'(core_rvalid), 64'hF);
    chk("R9 core_rdata", 64'(core_rdata), 64'hCAFE_0123);
    chk("R9 no gnt on return", 64'(core_gnt), 0);
    @(negedge clk); bus_rvalid = 1'b0; #1;
    chk("R9 gnt after return", 64'(core_gnt), 64'hF);
    chk("R9 rvalid low", 64'(core_rvalid), 0);
    push(16'h4100, 1, 32'h77, 0);
    @(negedge clk); put_all(0, 0, 0, 0);
    repeat (2) @(negedge clk);

    // R10: switch to pair mode while idle
    mode_req = 2'd1;
    @(negedge clk); #1;
    chk("R10 mode pair", 64'(mode_cur), 1);

    // R4: both pairs agree; last grant was channel 0 so pair 1 goes first
    @(negedge clk);
    set_core(0, 1, 1, 16'h5000, 32'h50); set_core(1, 1, 1, 16'h5000, 32'h50);
    set_core(2, 1, 1, 16'h5100, 32'h51); set_core(3, 1, 1, 16'h5100, 32'h51); #1;
    chk("R4 pair1 gnt", 64'(core_gnt), 64'b1100);
    push(16'h5100, 1, 32'h51, 1);
    @(negedge clk); set_core(2, 0, 0, 0, 0); set_core(3, 0, 0, 0, 0); #1;
    chk("R4 pair0 gnt", 64'(core_gnt), 64'b0011);
    push(16'h5000, 1, 32'h50, 0);
    @(negedge clk); put_all(0, 0, 0, 0);
    repeat (2) @(negedge clk);

    // R5: pair 1 write data mismatch, pair 0 served
    set_core(0, 1, 1, 16'h6000, 32'h60); set_core(1, 1, 1, 16'h6000, 32'h60);
    set_core(2, 1, 1, 16'h6100, 32'h61); set_core(3, 1, 1, 16'h6100, 32'h62); #1;
    chk("R5 pair0 gnt", 64'(core_gnt), 64'b0011);
    push(16'h6000, 1, 32'h60, 0);
    @(negedge clk); set_core(0, 0, 0, 0, 0); set_core(1, 0, 0, 0, 0); #1;
    chk("R5 pair1 blocked", 64'(core_gnt), 0);
    chk("R5 pair_err", 64'(pair_err), 64'b10);
    put_all(0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R11 pair_err sticky", 64'(pair_err), 64'b10);
    pulse_clear(); #1;
    chk("R11 pair_err cleared", 64'(pair_err), 0);

    // R10/R9: mode change deferred behind an outstanding read
    @(negedge clk);
    set_core(2, 1, 0, 16'h7000, 0); set_core(3, 1, 0, 16'h7000, 0); #1;
    chk("R4 pair1 read gnt", 64'(core_gnt), 64'b1100);
    push(16'h7000, 0, 0, 1);
    @(negedge clk); put_all(0, 0, 0, 0); mode_req = 2'd2;
    @(negedge clk); #1;
    chk("R10 mode held", 64'(mode_cur), 1);
    bus_rvalid = 1'b1; bus_rdata = 32'h0BAD_F00D; #1;
    chk("R9 pair1 rvalid", 64'(core_rvalid), 64'b1100);
    @(negedge clk); bus_rvalid = 1'b0; #1;
    chk("R10 mode held on return", 64'(mode_cur), 1);
    @(negedge clk); #1;
    chk("R10 mode free", 64'(mode_cur), 2);

    // R6: four independent writes, last grant was channel 1
    @(negedge clk);
    for (int i = 0; i < NC; i++) set_core(i, 1, 1, 16'h8000 + 16'(i), 32'h80 + i);
    for (int k = 0; k < NC; k++) begin
      int ch;
      ch = (2 + k) % NC;
      #1;
      chk("R6 rotation", 64'(core_gnt), 64'(1 << ch));
      push(16'h8000 + 16'(ch), 1, 32'h80 + ch, 2'(ch));
      @(negedge clk); set_core(ch, 0, 0, 0, 0);
    end

    // R10: code 3 ignored
    mode_req = 2'd3;
    repeat (3) @(negedge clk); #1;
    chk("R10 code 3 ignored", 64'(mode_cur), 2);

    repeat (3) @(negedge clk);
    chk("R8 all expected seen", 64'(q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule